// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block drives a byte-wide parallel NOR flash through its address lines, its bidirectional data lines and its active-low chip-enable, output-enable and write-enable strobes. A host hands it one operation at a time: a byte program, a sector erase, a block erase or a whole-chip erase. Each request carries an address and a data byte. The block issues the unlock and command write cycles that the flash expects. It then polls the flash until the internal operation has finished and pulses `done`. If completion does not arrive within a limit, it pulses `timeout_err` instead.

End-of-write detection has two forms, picked per request by `poll_mode`. The first watches bit 7 of a status read, which shows the complement of the final value until the array settles. The second watches bit 6, which alternates on every read while the flash is busy. The end of the internal write is asynchronous, so a status read that lands on it can look finished while it is not. For that reason a poll that first looks finished must be followed by one more read that agrees before the block reports success. All strobe widths are parameter counts of clock cycles, and every parameter must be at least 1.

Top module: `flash_wr_ctrl`

## Requirements
- R1: After reset `ready` is 1, `done` and `timeout_err` are 0, and `fl_ce_n`, `fl_oe_n` and `fl_we_n` are all 1.
- R2: A program request (`req_op`=0) produces exactly four write cycles, given as data@address: AAh@5555h, then 55h@2AAAh, then A0h@5555h, then the request data at the request address.
- R3: An erase request produces exactly six write cycles. The first five are AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh. The sixth is 30h at the request address for sector erase (`req_op`=1), 50h at the request address for block erase (`req_op`=2), or 10h at 5555h for chip erase (`req_op`=3).
- R4: In every write cycle `fl_ce_n` is low for exactly T_SETUP clock cycles before `fl_we_n` falls. `fl_we_n` then stays low for exactly T_WP cycles, and address and data do not change while it is low. `fl_we_n` and `fl_oe_n` are never low together.
- R5: With `poll_mode`=0 the block reads the target address. A read counts as finished only when bit 7 equals the expected final value: data bit 7 for a program, 1 for any erase.
- R6: With `poll_mode`=1 a read counts as finished only when its bit 6 equals bit 6 of the read just before it in the same poll.
- R7: `done` is raised only after two consecutive polling reads count as finished. A single read that wrongly looks finished, followed by one that does not, does not end the operation.
- R8: `done` is a one-cycle pulse. In the same cycle `ready` returns to 1, and `fl_ce_n`, `fl_oe_n` and `fl_we_n` are all 1.
- R9: If polling has run for at least PROG_TMO cycles (program) or ERASE_TMO cycles (erase) when a read finishes without completion, the block pulses `timeout_err` instead of `done`, returns to ready and leaves all enables high. The limit is therefore reached no later than one read cycle after it expires.
- R10: A request is taken only while `ready` is 1. `ready` is 0 from the cycle after acceptance until `done` or `timeout_err`, and a `req_valid` during that time produces no extra bus cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while ready is 1 |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target address |
| req_data | input | 8 | Byte to program |
| poll_mode | input | 1 | 0 bit-7 data polling, 1 bit-6 toggle polling |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse on confirmed completion |
| timeout_err | output | 1 | One-cycle pulse when polling exceeds its limit |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Data output enable toward the flash |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The bench goes through every operation in both polling modes against a flash model that checks strobe widths, and compares each command stream word by word. A sequencer with a wrong unlock constant, a missing erase cycle or a sixth cycle at the wrong address would show a sequence mismatch. The model can return one false completion indication in the middle of a busy period. A design without the confirming read would report `done` while the model is still busy. A stuck-busy flash must end in `timeout_err` inside a window set by the program or erase limit, with the bus released. A request poked in mid-operation must not add write cycles.

// File: rtl/flash_wr_pkg.sv
package flash_wr_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } flash_op_e;

  localparam logic [7:0]  KEY_HI    = 8'hAA;
  localparam logic [7:0]  KEY_LO    = 8'h55;
  localparam logic [7:0]  CODE_PROG = 8'hA0;
  localparam logic [7:0]  CODE_ERS  = 8'h80;
  localparam logic [7:0]  CODE_SECT = 8'h30;
  localparam logic [7:0]  CODE_BLK  = 8'h50;
  localparam logic [7:0]  CODE_CHIP = 8'h10;
  localparam logic [15:0] LOC_P     = 16'h5555;
  localparam logic [15:0] LOC_Q     = 16'h2AAA;

endpackage

// File: rtl/fwc_cmd_seq.sv
module fwc_cmd_seq
  import flash_wr_pkg::*;
#(
  parameter int AW = 20
) (
  input  flash_op_e       op,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   tgt_addr,
  input  logic [7:0]      tgt_data,
  output logic [AW-1:0]   wr_addr,
  output logic [7:0]      wr_data,
  output logic            last
);

  localparam logic [AW-1:0] A_P = AW'(LOC_P);
  localparam logic [AW-1:0] A_Q = AW'(LOC_Q);

  always_comb begin
    wr_addr = A_P;
    wr_data = KEY_HI;
    last    = 1'b0;
    if (op == OP_PROG) begin
      case (step)
        3'd0: begin wr_addr = A_P; wr_data = KEY_HI; end
        3'd1: begin wr_addr = A_Q; wr_data = KEY_LO; end
        3'd2: begin wr_addr = A_P; wr_data = CODE_PROG; end
        default: begin wr_addr = tgt_addr; wr_data = tgt_data; last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin wr_addr = A_P; wr_data = KEY_HI; end
        3'd1: begin wr_addr = A_Q; wr_data = KEY_LO; end
        3'd2: begin wr_addr = A_P; wr_data = CODE_ERS; end
        3'd3: begin wr_addr = A_P; wr_data = KEY_HI; end
        3'd4: begin wr_addr = A_Q; wr_data = KEY_LO; end
        default: begin
          last = 1'b1;
          case (op)
            OP_SECT: begin wr_addr = tgt_addr; wr_data = CODE_SECT; end
            OP_BLK:  begin wr_addr = tgt_addr; wr_data = CODE_BLK; end
            default: begin wr_addr = A_P;      wr_data = CODE_CHIP; end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/fwc_bus_seq.sv
module fwc_bus_seq #(
  parameter int AW      = 20,
  parameter int T_SETUP = 2,
  parameter int T_WP    = 3,
  parameter int T_WPH   = 2,
  parameter int T_RD    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic [7:0]    dq_in,
  output logic          fin,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);

  localparam int M_A  = (T_SETUP > T_WP) ? T_SETUP : T_WP;
  localparam int M_B  = (T_WPH > T_RD) ? T_WPH : T_RD;
  localparam int TMAX = (M_A > M_B) ? M_A : M_B;
  localparam int CW   = $clog2(TMAX + 1);

  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_PULSE, B_HOLD, B_READ} bst_e;
  bst_e          bst;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bst       <= B_IDLE;
      cnt       <= '0;
      fin       <= 1'b0;
      rdata     <= '0;
      fl_addr   <= '0;
      fl_dq_out <= '0;
      fl_dq_oe  <= 1'b0;
      fl_ce_n   <= 1'b1;
      fl_oe_n   <= 1'b1;
      fl_we_n   <= 1'b1;
    end else begin
      fin <= 1'b0;
      case (bst)
        B_IDLE: if (start) begin
          fl_addr <= addr;
          fl_ce_n <= 1'b0;
          if (is_read) begin
            fl_oe_n <= 1'b0;
            cnt     <= CW'(T_RD - 1);
            bst     <= B_READ;
          end else begin
            fl_dq_out <= wdata;
            fl_dq_oe  <= 1'b1;
            cnt       <= CW'(T_SETUP - 1);
            bst       <= B_SETUP;
          end
        end
        B_SETUP: if (cnt == '0) begin
          fl_we_n <= 1'b0;
          cnt     <= CW'(T_WP - 1);
          bst     <= B_PULSE;
        end else cnt <= cnt - 1'b1;
        B_PULSE: if (cnt == '0) begin
          fl_we_n <= 1'b1;
          cnt     <= CW'(T_WPH - 1);
          bst     <= B_HOLD;
        end else cnt <= cnt - 1'b1;
        B_HOLD: if (cnt == '0) begin
          fl_ce_n  <= 1'b1;
          fl_dq_oe <= 1'b0;
          fin      <= 1'b1;
          bst      <= B_IDLE;
        end else cnt <= cnt - 1'b1;
        B_READ: if (cnt == '0) begin
          rdata   <= dq_in;
          fl_oe_n <= 1'b1;
          fl_ce_n <= 1'b1;
          fin     <= 1'b1;
          bst     <= B_IDLE;
        end else cnt <= cnt - 1'b1;
        default: bst <= B_IDLE;
      endcase
    end
  end

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we_n) |-> (!fl_ce_n && !$past(fl_ce_n)));

  // R4
  we_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_out) && fl_dq_oe));

endmodule

// File: rtl/fwc_poll_eval.sv
module fwc_poll_eval #(
  parameter int CONFIRM = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       rd_fin,
  input  logic [7:0] rd_data,
  input  logic       exp_b7,
  input  logic       tog_mode,
  output logic       complete
);

  localparam int SW = $clog2(CONFIRM + 1);

  logic [SW-1:0] streak;
  logic          prev_b6;
  logic          have_prev;
  logic          hit;

  always_comb begin
    if (tog_mode) hit = have_prev && (rd_data[6] == prev_b6);
    else          hit = (rd_data[7] == exp_b7);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      streak    <= '0;
      prev_b6   <= 1'b0;
      have_prev <= 1'b0;
      complete  <= 1'b0;
    end else if (rd_fin) begin
      prev_b6   <= rd_data[6];
      have_prev <= 1'b1;
      if (hit) begin
        if (streak != SW'(CONFIRM)) streak <= streak + 1'b1;
        complete <= (streak >= SW'(CONFIRM - 1));
      end else begin
        streak   <= '0;
        complete <= 1'b0;
      end
    end
  end

  // R7
  complete_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(complete) |-> $past(rd_fin));

endmodule

// File: rtl/flash_wr_ctrl.sv
module flash_wr_ctrl
  import flash_wr_pkg::*;
#(
  parameter int AW        = 20,
  parameter int T_SETUP   = 2,
  parameter int T_WP      = 3,
  parameter int T_WPH     = 2,
  parameter int T_RD      = 3,
  parameter int PROG_TMO  = 2000,
  parameter int ERASE_TMO = 2000000,
  parameter int CONFIRM   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          poll_mode,
  output logic          ready,
  output logic          done,
  output logic          timeout_err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n
);

  localparam int TMO_MAX = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
  localparam int TMW     = $clog2(TMO_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WWAIT, S_PREAD, S_RWAIT, S_JUDGE} st_e;

  st_e            st;
  flash_op_e      op_q;
  logic [AW-1:0]  addr_q;
  logic [7:0]     data_q;
  logic           tog_q;
  logic [2:0]     step;
  logic [TMW-1:0] tmr;
  logic [TMW-1:0] tmo_lim;

  logic [AW-1:0]  cmd_addr;
  logic [7:0]     cmd_data;
  logic           cmd_last;
  logic           bus_start;
  logic           bus_read;
  logic [AW-1:0]  bus_addr;
  logic           bus_fin;
  logic [7:0]     bus_rdata;
  logic           poll_clr;
  logic           exp_b7;
  logic           complete;

  fwc_cmd_seq #(.AW(AW)) u_cmd (
    .op       (op_q),
    .step     (step),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .wr_addr  (cmd_addr),
    .wr_data  (cmd_data),
    .last     (cmd_last)
  );

  assign bus_read  = (st == S_PREAD);
  assign bus_start = (st == S_ISSUE) || (st == S_PREAD);
  assign bus_addr  = bus_read ? addr_q : cmd_addr;

  fwc_bus_seq #(
    .AW(AW), .T_SETUP(T_SETUP), .T_WP(T_WP), .T_WPH(T_WPH), .T_RD(T_RD)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .start     (bus_start),
    .is_read   (bus_read),
    .addr      (bus_addr),
    .wdata     (cmd_data),
    .dq_in     (fl_dq_in),
    .fin       (bus_fin),
    .rdata     (bus_rdata),
    .fl_addr   (fl_addr),
    .fl_dq_out (fl_dq_out),
    .fl_dq_oe  (fl_dq_oe),
    .fl_ce_n   (fl_ce_n),
    .fl_oe_n   (fl_oe_n),
    .fl_we_n   (fl_we_n)
  );

  assign exp_b7   = (op_q == OP_PROG) ? data_q[7] : 1'b1;
  assign poll_clr = (st == S_WWAIT) && bus_fin && cmd_last;
  assign tmo_lim  = (op_q == OP_PROG) ? TMW'(PROG_TMO) : TMW'(ERASE_TMO);

  fwc_poll_eval #(.CONFIRM(CONFIRM)) u_poll (
    .clk      (clk),
    .rst      (rst),
    .clr      (poll_clr),
    .rd_fin   (bus_fin && (st == S_RWAIT)),
    .rd_data  (bus_rdata),
    .exp_b7   (exp_b7),
    .tog_mode (tog_q),
    .complete (complete)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      ready       <= 1'b1;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      tog_q       <= 1'b0;
      step        <= '0;
      tmr         <= '0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      if ((st == S_PREAD || st == S_RWAIT || st == S_JUDGE) && (tmr != '1))
        tmr <= tmr + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q   <= flash_op_e'(req_op);
          addr_q <= req_addr;
          data_q <= req_data;
          tog_q  <= poll_mode;
          step   <= '0;
          ready  <= 1'b0;
          st     <= S_ISSUE;
        end
        S_ISSUE: st <= S_WWAIT;
        S_WWAIT: if (bus_fin) begin
          if (cmd_last) begin
            tmr <= '0;
            st  <= S_PREAD;
          end else begin
            step <= step + 1'b1;
            st   <= S_ISSUE;
          end
        end
        S_PREAD: st <= S_RWAIT;
        S_RWAIT: if (bus_fin) st <= S_JUDGE;
        S_JUDGE: begin
          if (complete) begin
            done  <= 1'b1;
            ready <= 1'b1;
            st    <= S_IDLE;
          end else if (tmr >= tmo_lim) begin
            timeout_err <= 1'b1;
            ready       <= 1'b1;
            st          <= S_IDLE;
          end else begin
            st <= S_PREAD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_oe_n));

  // R8
  idle_enables_chk: assert property (@(posedge clk) disable iff (rst)
    fl_ce_n |-> (fl_we_n && fl_oe_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  end_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    (done || timeout_err) |-> (fl_ce_n && ready && !(done && timeout_err)));

  // R10
  accept_only_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(req_valid));

endmodule

// File: tb/flash_wr_ctrl_test.sv
module flash_wr_ctrl_test;

  localparam int AW    = 16;
  localparam int TS    = 1;
  localparam int TWP   = 2;
  localparam int TWPH  = 1;
  localparam int TRD   = 2;
  localparam int PTMO  = 300;
  localparam int ETMO  = 600;
  localparam int BUSYP = 40;
  localparam int BUSYE = 80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          poll_mode = 1'b0;
  logic          ready, done, timeout_err;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out;
  logic          fl_dq_oe;
  logic [7:0]    fl_dq_in;
  logic          fl_ce_n, fl_oe_n, fl_we_n;

  always #4 clk = ~clk;

  flash_wr_ctrl #(
    .AW(AW), .T_SETUP(TS), .T_WP(TWP), .T_WPH(TWPH), .T_RD(TRD),
    .PROG_TMO(PTMO), .ERASE_TMO(ETMO), .CONFIRM(2)
  ) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .poll_mode(poll_mode),
    .ready(ready), .done(done), .timeout_err(timeout_err),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
  );

  // ---------------- flash model (written only here) ----------------
  logic [7:0]  mem [0:255];
  logic [15:0] log_addr [0:255];
  logic [7:0]  log_data [0:255];
  int          log_n = 0;
  int          tim_err = 0;
  int          busy_cnt = 0;
  int          busy_rd = 0;
  int          su_cnt = 0;
  int          lo_cnt = 0;
  logic        prev_we = 1'b1, prev_oe = 1'b1;
  logic [15:0] fall_addr = '0;
  logic [7:0]  fall_dq = '0;
  logic        exp7 = 1'b1;
  logic        tb6 = 1'b0;
  logic [7:0]  dq_mod = 8'h00;
  // stimulus-side controls (written only by the bench)
  logic        stuck = 1'b0;
  logic        glitch_arm = 1'b0;

  assign fl_dq_in = dq_mod;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
      busy_cnt <= 0;
      prev_we  <= 1'b1;
      prev_oe  <= 1'b1;
      su_cnt   <= 0;
      lo_cnt   <= 0;
    end else begin
      prev_we <= fl_we_n;
      prev_oe <= fl_oe_n;
      if (fl_ce_n) su_cnt <= 0;
      else if (fl_we_n) su_cnt <= su_cnt + 1;
      if (!fl_we_n) lo_cnt <= lo_cnt + 1;
      if (prev_we && !fl_we_n) begin
        if (su_cnt != TS) tim_err <= tim_err + 1;
        fall_addr <= fl_addr;
        fall_dq   <= fl_dq_out;
      end
      if (!prev_we && fl_we_n && !fl_ce_n) begin
        lo_cnt <= 0;
        if (lo_cnt != TWP || fall_addr != fl_addr || fall_dq != fl_dq_out || !fl_dq_oe)
          tim_err <= tim_err + 1;
        log_addr[log_n[7:0]] <= fl_addr;
        log_data[log_n[7:0]] <= fl_dq_out;
        log_n <= log_n + 1;
        if (log_n >= 3 && log_data[8'(log_n-1)] == 8'hA0 && log_data[8'(log_n-2)] == 8'h55) begin
          mem[fl_addr[7:0]] <= mem[fl_addr[7:0]] & fl_dq_out;
          exp7     <= fl_dq_out[7];
          busy_cnt <= BUSYP;
          busy_rd  <= 0;
        end else if (log_n >= 5 && log_data[8'(log_n-1)] == 8'h55 &&
                     log_data[8'(log_n-3)] == 8'h80 &&
                     (fl_dq_out == 8'h30 || fl_dq_out == 8'h50 || fl_dq_out == 8'h10)) begin
          for (int i = 0; i < 256; i++) mem[i] <= 8'hFF;
          exp7     <= 1'b1;
          busy_cnt <= BUSYE;
          busy_rd  <= 0;
        end
      end else if (busy_cnt != 0 && !stuck) begin
        busy_cnt <= busy_cnt - 1;
      end
      if (prev_oe && !fl_oe_n) begin
        if (busy_cnt != 0) begin
          busy_rd <= busy_rd + 1;
          if (glitch_arm && busy_rd == 1) begin
            dq_mod <= {exp7, tb6, 6'b0};
          end else begin
            tb6    <= ~tb6;
            dq_mod <= {~exp7, ~tb6, 6'b0};
          end
        end else begin
          dq_mod <= mem[fl_addr[7:0]];
        end
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int fails = 0;
  int wd = 0;
  int base_n = 0;
  int base_t = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=0", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic exp_wr(input int op, input int k, input logic [15:0] a,
                        input logic [7:0] d, output logic [15:0] ea,
                        output logic [7:0] ed);
    ea = 16'h5555; ed = 8'hAA;
    if (op == 0) begin
      case (k)
        0: begin ea = 16'h5555; ed = 8'hAA; end
        1: begin ea = 16'h2AAA; ed = 8'h55; end
        2: begin ea = 16'h5555; ed = 8'hA0; end
        default: begin ea = a; ed = d; end
      endcase
    end else begin
      case (k)
        0: begin ea = 16'h5555; ed = 8'hAA; end
        1: begin ea = 16'h2AAA; ed = 8'h55; end
        2: begin ea = 16'h5555; ed = 8'h80; end
        3: begin ea = 16'h5555; ed = 8'hAA; end
        4: begin ea = 16'h2AAA; ed = 8'h55; end
        default: begin
          if (op == 1) begin ea = a; ed = 8'h30; end
          else if (op == 2) begin ea = a; ed = 8'h50; end
          else begin ea = 16'h5555; ed = 8'h10; end
        end
      endcase
    end
  endtask

  task automatic run_op(input int op, input logic [15:0] a, input logic [7:0] d,
                        input logic mode, input bit poke, output int res,
                        output int cyc, output int busy_done, output int rdy_hi);
    res = 2; cyc = 0; busy_done = 0; rdy_hi = 0;
    @(negedge clk);
    base_n = log_n;
    base_t = tim_err;
    req_op = op[1:0]; req_addr = a; req_data = d; poll_mode = mode; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (cyc < 20000 && res == 2) begin
      cyc++;
      if (poke && cyc == 12) begin req_op = 2'd3; req_valid = 1'b1; end
      else req_valid = 1'b0;
      if (done) begin res = 0; busy_done = (busy_cnt != 0) ? 1 : 0; end
      else if (timeout_err) res = 1;
      else if (ready) rdy_hi = 1;
      if (res == 2) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic seq_check(input int op, input logic [15:0] a, input logic [7:0] d);
    int n_exp;
    int mm;
    logic [15:0] ea;
    logic [7:0] ed;
    n_exp = (op == 0) ? 4 : 6;
    mm = 0;
    chk(log_n - base_n == n_exp, (op == 0) ? "R2" : "R3", "write count",
        log_n - base_n, n_exp);
    for (int k = 0; k < n_exp; k++) begin
      exp_wr(op, k, a, d, ea, ed);
      if (log_addr[8'(base_n + k)] != ea || log_data[8'(base_n + k)] != ed) begin
        mm++;
        $display("  mismatch step %0d addr=%h data=%h want %h/%h", k,
                 log_addr[8'(base_n + k)], log_data[8'(base_n + k)], ea, ed);
      end
    end
    chk(mm == 0, (op == 0) ? "R2" : "R3", "command stream mismatches", mm, 0);
    chk(tim_err == base_t, "R4", "strobe timing violations", tim_err - base_t, 0);
  endtask

  task automatic post_check(input string req);
    @(negedge clk);
    chk(done == 1'b0, "R8", {req, " done single pulse"}, int'(done), 0);
    chk(ready == 1'b1, "R8", {req, " ready back"}, int'(ready), 1);
    chk({fl_ce_n, fl_oe_n, fl_we_n} == 3'b111, "R8", {req, " enables released"},
        int'({fl_ce_n, fl_oe_n, fl_we_n}), 7);
  endtask

  initial begin
    int res, cyc, bd, rh;
    logic [15:0] a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1", "ready after reset", int'(ready), 1);
    chk(done == 1'b0 && timeout_err == 1'b0, "R1", "no pulses after reset",
        int'({done, timeout_err}), 0);
    chk({fl_ce_n, fl_oe_n, fl_we_n} == 3'b111, "R1", "enables idle after reset",
        int'({fl_ce_n, fl_oe_n, fl_we_n}), 7);

    // sweep of every operation in both polling modes
    for (int op = 0; op < 4; op++) begin
      for (int m = 0; m < 2; m++) begin
        a = 16'h0010 + 16'(op * 2 + m) + ((op != 0) ? 16'h1000 : 16'h0);
        d = (m == 0) ? 8'hC3 : 8'h5A;
        run_op(op, a, d, m[0], 1'b0, res, cyc, bd, rh);
        chk(res == 0, (m == 0) ? "R5" : "R6", $sformatf("op%0d completes", op), res, 0);
        chk(bd == 0, "R7", $sformatf("op%0d done while flash busy", op), bd, 0);
        chk(rh == 0, "R10", $sformatf("op%0d ready low while busy", op), rh, 0);
        seq_check(op, a, d);
        post_check($sformatf("op%0d", op));
      end
    end

    // R7: one false completion read mid-busy, both modes
    for (int m = 0; m < 2; m++) begin
      glitch_arm = 1'b1;
      a = 16'h0020 + 16'(m);
      d = (m == 0) ? 8'h3C : 8'hA5;
      run_op(0, a, d, m[0], 1'b0, res, cyc, bd, rh);
      glitch_arm = 1'b0;
      chk(res == 0, "R7", $sformatf("glitch mode%0d completes", m), res, 0);
      chk(bd == 0, "R7", $sformatf("glitch mode%0d done only after busy ends", m), bd, 1'b0);
      post_check("R7 glitch");
    end

    // R10: request poked in mid-operation is ignored
    a = 16'h0030; d = 8'h81;
    run_op(0, a, d, 1'b0, 1'b1, res, cyc, bd, rh);
    chk(res == 0, "R10", "poked op completes", res, 0);
    chk(rh == 0, "R10", "ready low while poked", rh, 0);
    seq_check(0, a, d);
    post_check("R10");

    // R9: program timeout with stuck busy
    stuck = 1'b1;
    a = 16'h0040; d = 8'h00;
    run_op(0, a, d, 1'b0, 1'b0, res, cyc, bd, rh);
    chk(res == 1, "R9", "program timeout raised", res, 1);
    chk(cyc >= PTMO && cyc <= PTMO + 100, "R9", "program timeout window", cyc, PTMO);
    post_check("R9 prog");
    stuck = 1'b0;
    repeat (BUSYE + 20) @(negedge clk);

    // R9: erase uses the longer limit
    stuck = 1'b1;
    a = 16'h2000;
    run_op(1, a, 8'h00, 1'b1, 1'b0, res, cyc, bd, rh);
    chk(res == 1, "R9", "erase timeout raised", res, 1);
    chk(cyc >= ETMO && cyc <= ETMO + 120, "R9", "erase timeout window", cyc, ETMO);
    post_check("R9 erase");
    stuck = 1'b0;
    repeat (BUSYE + 20) @(negedge clk);

    // recovery after timeout: a normal program still works
    a = 16'h0050; d = 8'h7E;
    run_op(0, a, d, 1'b0, 1'b0, res, cyc, bd, rh);
    chk(res == 0, "R5", "program after timeout", res, 0);
    seq_check(0, a, d);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule